// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution unit sits in the integer datapath of a 32-bit processor. It forms `acc + a*b` or `acc - a*b` in a single cycle. `a` is a register operand. `b` is either a second register operand or a 9-bit immediate. The accumulator, and the result written back, is either one 32-bit word or a 64-bit register pair, with the low word in register n and the high word in register n+1. The register file, the decoder and the writeback sequencer sit outside the unit. They present the operands, a mode code and an add/subtract select, and pulse `op_valid` for one cycle per operation.

Each operation comes in three arithmetic flavours. Signed wrap keeps the truncated low bits of the exact result. Signed saturate clamps to the signed limits of the destination width. Unsigned saturate clamps to all ones or to zero. In every flavour the full 64-bit product is formed before the accumulate step, and overflow is judged against the exact result.

The unit reports four status bits:
- an overflow flag for the last operation;
- an advance-overflow flag, which warns that the top two bits of the result differ;
- two sticky copies of those flags, which collect every event since reset.

Top module: `mac_sat_unit`

## Requirements
- R1: The unit computes the exact value of the accumulator plus or minus the full-width product of the two operands. `op_sub`=0 adds and `op_sub`=1 subtracts. In a non-saturating mode the result is that exact value truncated to the destination width.
- R2: The mode code `op_mode` has three fields:
  - bit 0 = signed operands (1) or unsigned (0);
  - bit 1 = 64-bit accumulator and result (1) or 32-bit (0);
  - bit 2 = saturate (1) or wrap (0).

  The subtract group therefore uses 0x02 for unsigned 64-bit, 0x03 for signed 64-bit, 0x04 for unsigned saturating 32-bit, 0x05 for saturating 32-bit, 0x06 for unsigned saturating 64-bit and 0x07 for saturating 64-bit.
- R3: In 32-bit modes, `ovf` is set when the exact result lies outside [-2^31, 2^31-1] (signed) or outside [0, 2^32-1] (unsigned), and is cleared otherwise.
- R4: In 64-bit modes, only the accumulate step can overflow.
  - Signed: `ovf` is set when the exact result lies outside the signed 64-bit range.
  - Unsigned add: `ovf` is set when the sum is below the accumulator.
  - Unsigned subtract: `ovf` is set when the product exceeds the accumulator.
- R5: In a signed saturating mode, an overflowing result clamps to the signed maximum of the destination width when the exact value is too large. It clamps to the signed minimum when the exact value is too small.
- R6: In an unsigned saturating mode, an overflowing result clamps to all ones when the exact value is too large, and to zero when it is negative.
- R7: With `use_imm`=1, operand b is the 9-bit immediate. The immediate is sign-extended in signed modes and zero-extended in unsigned modes. With `use_imm`=0, `src_b` is used and the immediate is ignored.
- R8: `adv_ovf` equals bit 31 XOR bit 30 of a 32-bit result, or bit 63 XOR bit 62 of a 64-bit result.
- R9: `sticky_ovf` and `sticky_adv` reset to 0. On each `op_valid` they OR in the new `ovf` and `adv_ovf`. They never clear except by reset.
- R10: Results and flags are registered. They appear, with `res_valid`=1, on the clock edge that samples `op_valid`=1, and hold unchanged while `op_valid`=0. A 32-bit result has its upper word equal to zero.
- R11: After reset, `res_out`, every flag and `res_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe, operation present |
| op_sub | input | 1 | 0 = multiply-add, 1 = multiply-subtract |
| op_mode | input | 3 | {saturate, wide, signed} |
| use_imm | input | 1 | Select immediate as operand b |
| imm | input | 9 | Immediate operand |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Register multiplier |
| acc_in | input | 64 | Accumulator (pair {n+1, n}; low word only in 32-bit modes) |
| res_valid | output | 1 | Result registered this cycle |
| res_out | output | 64 | Result |
| ovf | output | 1 | Overflow of last operation |
| sticky_ovf | output | 1 | Sticky overflow |
| adv_ovf | output | 1 | Advance overflow of last operation |
| sticky_adv | output | 1 | Sticky advance overflow |

## Verification
The assertions check the following on every cycle:
- the result and its valid bit follow the strobe by exactly one edge;
- idle cycles disturb nothing;
- the sticky bits never fall and always cover the live flags;
- advance overflow matches the top two bits of the result;
- 32-bit results carry a zero upper word;
- a saturated result is one of the legal clamp values.

Only the bench's scenarios can show the rest. These are whether the arithmetic value is right and whether overflow fires on exactly the right boundaries. They also include the clamp direction, the immediate extension and reset clearing the sticky bits. The bench compares each case against a 128-bit exact model.

// File: rtl/mac_pkg.sv
package mac_pkg;
    // Mode code fields; bit order is fixed by the decoder upstream.
    typedef struct packed {
        logic sat;   // bit 2
        logic wide;  // bit 1
        logic sgn;   // bit 0
    } mac_mode_t;
endpackage

// File: rtl/mac_opnd.sv
// Operand conditioning: immediate extension, b selection, extension to
// the exact-arithmetic width.
module mac_opnd #(
    parameter int W     = 32,
    parameter int IMM_W = 9
) (
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             sgn,
    output logic [2*W+1:0]   a_x,
    output logic [2*W+1:0]   b_x
);
    localparam int XW = 2*W + 2;

    logic [W-1:0] imm_ext;
    logic [W-1:0] b_sel;

    // R7: sign- or zero-extension of the immediate follows the mode
    assign imm_ext = {{(W-IMM_W){sgn & imm[IMM_W-1]}}, imm};
    assign b_sel   = use_imm ? imm_ext : src_b;

    assign a_x = {{(XW-W){sgn & src_a[W-1]}}, src_a};
    assign b_x = {{(XW-W){sgn & b_sel[W-1]}}, b_sel};
endmodule

// File: rtl/mac_core.sv
// Exact multiply-accumulate: two guard bits above 64 hold any result.
module mac_core #(
    parameter int W = 32
) (
    input  logic [2*W+1:0] a_x,
    input  logic [2*W+1:0] b_x,
    input  logic [2*W-1:0] acc,
    input  logic           sgn,
    input  logic           wide,
    input  logic           sub,
    output logic [2*W+1:0] exact
);
    localparam int DW = 2*W;
    localparam int XW = DW + 2;

    logic [XW-1:0] prod;
    logic [XW-1:0] acc_n;
    logic [XW-1:0] acc_w;
    logic [XW-1:0] acc_x;

    // R1: full-width product before the accumulate step
    assign prod  = a_x * b_x;
    assign acc_n = {{(XW-W){sgn & acc[W-1]}}, acc[W-1:0]};
    assign acc_w = {{(XW-DW){sgn & acc[DW-1]}}, acc};
    assign acc_x = wide ? acc_w : acc_n;
    assign exact = sub ? (acc_x - prod) : (acc_x + prod);
endmodule

// File: rtl/mac_clamp.sv
// Range check and saturation against a 1x or 2x word target.
module mac_clamp #(
    parameter int W = 32
) (
    input  logic [2*W+1:0] exact,
    input  logic           sgn,
    input  logic           wide,
    input  logic           sat,
    output logic [2*W-1:0] res,
    output logic           ovf,
    output logic           adv
);
    localparam int DW = 2*W;
    localparam int XW = DW + 2;

    logic [1:0]         fit_v;
    logic [1:0][DW-1:0] cand;
    logic               neg;

    assign neg = exact[XW-1];

    for (genvar g = 0; g < 2; g++) begin : g_tgt
        localparam int T = W << g;
        logic          s_fit;
        logic          u_fit;
        logic          fit;
        logic [T-1:0]  val;
        logic [DW-1:0] ext;

        // R3/R4: exact value must lie inside the target range
        assign s_fit = (&exact[XW-1:T-1]) | ~(|exact[XW-1:T-1]);
        assign u_fit = ~(|exact[XW-1:T]);
        assign fit   = sgn ? s_fit : u_fit;

        always_comb begin
            val = exact[T-1:0];
            if (sat && !fit) begin
                if (sgn) begin
                    // R5: direction from the sign of the exact value
                    val = neg ? {1'b1, {(T-1){1'b0}}} : {1'b0, {(T-1){1'b1}}};
                end else begin
                    // R6: negative floors at zero, else all ones
                    val = neg ? '0 : '1;
                end
            end
            ext        = '0;
            ext[T-1:0] = val;
        end

        assign fit_v[g] = fit;
        assign cand[g]  = ext;
    end

    assign res = wide ? cand[1] : cand[0];
    assign ovf = wide ? ~fit_v[1] : ~fit_v[0];
    // R8: top two bits of the delivered result
    assign adv = wide ? (res[DW-1] ^ res[DW-2]) : (res[W-1] ^ res[W-2]);
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
    parameter int W     = 32,
    parameter int IMM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [2:0]       op_mode,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [2*W-1:0]   acc_in,
    output logic             res_valid,
    output logic [2*W-1:0]   res_out,
    output logic             ovf,
    output logic             sticky_ovf,
    output logic             adv_ovf,
    output logic             sticky_adv
);
    import mac_pkg::*;

    localparam int DW = 2*W;
    localparam int XW = DW + 2;

    mac_mode_t     mode;
    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;
    logic [XW-1:0] exact;
    logic [DW-1:0] res_c;
    logic          ovf_c;
    logic          adv_c;

    // R2: field decode of the mode code
    assign mode = mac_mode_t'(op_mode);

    mac_opnd #(.W(W), .IMM_W(IMM_W)) u_opnd (
        .src_a   (src_a),
        .src_b   (src_b),
        .imm     (imm),
        .use_imm (use_imm),
        .sgn     (mode.sgn),
        .a_x     (a_x),
        .b_x     (b_x)
    );

    mac_core #(.W(W)) u_core (
        .a_x   (a_x),
        .b_x   (b_x),
        .acc   (acc_in),
        .sgn   (mode.sgn),
        .wide  (mode.wide),
        .sub   (op_sub),
        .exact (exact)
    );

    mac_clamp #(.W(W)) u_clamp (
        .exact (exact),
        .sgn   (mode.sgn),
        .wide  (mode.wide),
        .sat   (mode.sat),
        .res   (res_c),
        .ovf   (ovf_c),
        .adv   (adv_c)
    );

    // R9/R10/R11: result register and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_out    <= '0;
            ovf        <= 1'b0;
            adv_ovf    <= 1'b0;
            sticky_ovf <= 1'b0;
            sticky_adv <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_out    <= res_c;
                ovf        <= ovf_c;
                adv_ovf    <= adv_c;
                sticky_ovf <= sticky_ovf | ovf_c;
                sticky_adv <= sticky_adv | adv_c;
            end
        end
    end
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
    parameter int W     = 32,
    parameter int IMM_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_mode,
    input logic             res_valid,
    input logic [2*W-1:0]   res_out,
    input logic             ovf,
    input logic             sticky_ovf,
    input logic             adv_ovf,
    input logic             sticky_adv
);
    localparam int DW = 2*W;

    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_idle_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_out) && $stable(ovf) && $stable(adv_ovf)));
    p_sticky_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(sticky_ovf) && $stable(sticky_adv)));
    p_sticky_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sticky_ovf) && !$fell(sticky_adv));
    p_sticky_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf || sticky_ovf) && (!adv_ovf || sticky_adv));
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_mode[1]) |=> (res_out[DW-1:W] == '0));
    p_adv_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (adv_ovf == ($past(op_mode[1]) ? (res_out[DW-1] ^ res_out[DW-2])
                                                    : (res_out[W-1] ^ res_out[W-2]))));
    p_ssat32_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 3'b101) |=>
        (!ovf || res_out[W-1:0] == {1'b0, {(W-1){1'b1}}} || res_out[W-1:0] == {1'b1, {(W-1){1'b0}}}));
    p_usat64_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 3'b110) |=> (!ovf || res_out == '1 || res_out == '0));
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_mode    (op_mode),
    .res_valid  (res_valid),
    .res_out    (res_out),
    .ovf        (ovf),
    .sticky_ovf (sticky_ovf),
    .adv_ovf    (adv_ovf),
    .sticky_adv (sticky_adv)
);

// File: tb/sim_mac_sat_unit.sv
`timescale 1ns/1ps
module sim_mac_sat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [2:0]  op_mode = 3'b0;
    logic        use_imm = 1'b0;
    logic [8:0]  imm = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [63:0] acc_in = '0;
    logic        res_valid;
    logic [63:0] res_out;
    logic        ovf, sticky_ovf, adv_ovf, sticky_adv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit sv_e = 1'b0;
    bit sav_e = 1'b0;

    always #2 clk = ~clk;

    mac_sat_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .op_mode(op_mode), .use_imm(use_imm), .imm(imm), .src_a(src_a),
        .src_b(src_b), .acc_in(acc_in), .res_valid(res_valid), .res_out(res_out),
        .ovf(ovf), .sticky_ovf(sticky_ovf), .adv_ovf(adv_ovf), .sticky_adv(sticky_adv)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 128-bit exact reference model built from the requirements
    task automatic ref_model(input bit sub, input logic [2:0] mode, input logic [31:0] a,
                             input logic [31:0] b, input bit ui, input logic [8:0] im,
                             input logic [63:0] acc, output logic [63:0] r,
                             output bit v, output bit av);
        bit sgn, wide, sat;
        int t;
        logic [31:0] bo;
        logic signed [127:0] ea, eb, ec, ex, hi, lo, rv;
        sgn = mode[0]; wide = mode[1]; sat = mode[2];
        bo = ui ? (sgn ? {{23{im[8]}}, im} : {23'b0, im}) : b;
        ea = sgn ? {{96{a[31]}}, a} : {96'b0, a};
        eb = sgn ? {{96{bo[31]}}, bo} : {96'b0, bo};
        if (wide) ec = sgn ? {{64{acc[63]}}, acc} : {64'b0, acc};
        else      ec = sgn ? {{96{acc[31]}}, acc[31:0]} : {96'b0, acc[31:0]};
        ex = sub ? (ec - ea * eb) : (ec + ea * eb);
        t = wide ? 64 : 32;
        if (sgn) begin
            hi = (128'sd1 <<< (t - 1)) - 128'sd1;
            lo = -(128'sd1 <<< (t - 1));
        end else begin
            hi = (128'sd1 <<< t) - 128'sd1;
            lo = 128'sd0;
        end
        v = (ex > hi) || (ex < lo);
        rv = ex;
        if (sat && ex > hi) rv = hi;
        if (sat && ex < lo) rv = lo;
        r = wide ? rv[63:0] : {32'b0, rv[31:0]};
        av = wide ? (r[63] ^ r[62]) : (r[31] ^ r[30]);
    endtask

    task automatic run_op(input string tag, input bit sub, input logic [2:0] mode,
                          input logic [31:0] a, input logic [31:0] b, input bit ui,
                          input logic [8:0] im, input logic [63:0] acc);
        logic [63:0] r;
        bit v, av;
        @(negedge clk);
        op_sub = sub; op_mode = mode; src_a = a; src_b = b;
        use_imm = ui; imm = im; acc_in = acc; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        ref_model(sub, mode, a, b, ui, im, acc, r, v, av);
        sv_e = sv_e | v;
        sav_e = sav_e | av;
        chk({tag, " R1 result"}, res_out, r);
        chk({tag, " R3/R4 ovf"}, {63'b0, ovf}, {63'b0, v});
        chk({tag, " R8 adv"}, {63'b0, adv_ovf}, {63'b0, av});
        chk({tag, " R9 sticky_ovf"}, {63'b0, sticky_ovf}, {63'b0, sv_e});
        chk({tag, " R9 sticky_adv"}, {63'b0, sticky_adv}, {63'b0, sav_e});
        chk({tag, " R10 res_valid"}, {63'b0, res_valid}, 64'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sv_e = 1'b0;
        sav_e = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R11 res_out", res_out, 64'd0);
        chk("R11 flags", {60'b0, ovf, adv_ovf, sticky_ovf, sticky_adv}, 64'd0);
        chk("R11 res_valid", {63'b0, res_valid}, 64'd0);
    endtask

    task automatic t_wrap_narrow();
        run_op("R1 mac32", 1'b0, 3'b001, 32'd7, 32'd6, 1'b0, 9'd0, 64'd100);
        run_op("R3 ovf32 hi", 1'b0, 3'b001, 32'd1, 32'd1, 1'b0, 9'd0, 64'h7FFFFFFF);
        run_op("R3 ovf32 lo", 1'b1, 3'b001, 32'd1, 32'd1, 1'b0, 9'd0, 64'h80000000);
        run_op("R3 clear", 1'b1, 3'b001, 32'd3, 32'd4, 1'b0, 9'd0, 64'd20);
        run_op("R3 uns32", 1'b0, 3'b000, 32'hFFFFFFFF, 32'd2, 1'b0, 9'd0, 64'd0);
        run_op("R2 sub32", 1'b1, 3'b001, 32'hFFFFFFFE, 32'd5, 1'b0, 9'd0, 64'hFFFFFFF0);
    endtask

    task automatic t_sat_narrow();
        run_op("R5 ssat32 max", 1'b0, 3'b101, 32'h40000000, 32'd2, 1'b0, 9'd0, 64'd1);
        run_op("R5 ssat32 min", 1'b1, 3'b101, 32'h40000000, 32'd4, 1'b0, 9'd0, 64'd0);
        run_op("R6 usat32 max", 1'b0, 3'b100, 32'h10000, 32'h10000, 1'b0, 9'd0, 64'd5);
        run_op("R6 usat32 zero", 1'b1, 3'b100, 32'd3, 32'd3, 1'b0, 9'd0, 64'd8);
        run_op("R5 ssat32 fit", 1'b0, 3'b101, 32'hFFFFFFFF, 32'd3, 1'b0, 9'd0, 64'd10);
    endtask

    task automatic t_wide_signed();
        run_op("R4 s64 max", 1'b0, 3'b111, 32'h80000000, 32'h80000000, 1'b0, 9'd0, 64'h7FFFFFFFFFFFFFFF);
        run_op("R4 s64 min", 1'b1, 3'b111, 32'h80000000, 32'h80000000, 1'b0, 9'h0, 64'h8000000000000000);
        run_op("R4 s64 wrap", 1'b0, 3'b011, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 9'd0, 64'h7FFFFFFFFFFFFFFF);
        run_op("R5 s64 neg prod sub", 1'b1, 3'b111, 32'hFFFFFFFF, 32'd9, 1'b0, 9'd0, 64'h7FFFFFFFFFFFFFFC);
        run_op("R1 s64 fit", 1'b1, 3'b011, 32'd1000, 32'hFFFFFC18, 1'b0, 9'd0, 64'h0000000123456789);
    endtask

    task automatic t_wide_unsigned();
        run_op("R4 u64 add ovf", 1'b0, 3'b010, 32'h10, 32'h10, 1'b0, 9'd0, 64'hFFFFFFFFFFFFFFF0);
        run_op("R6 u64 add sat", 1'b0, 3'b110, 32'h10, 32'h10, 1'b0, 9'd0, 64'hFFFFFFFFFFFFFFF0);
        run_op("R4 u64 sub ovf", 1'b1, 3'b010, 32'd2, 32'd3, 1'b0, 9'd0, 64'd5);
        run_op("R6 u64 sub sat", 1'b1, 3'b110, 32'd2, 32'd3, 1'b0, 9'd0, 64'd5);
        run_op("R4 u64 sub eq", 1'b1, 3'b110, 32'd2, 32'd3, 1'b0, 9'd0, 64'd6);
    endtask

    task automatic t_imm();
        run_op("R7 imm sext", 1'b0, 3'b001, 32'd10, 32'd77, 1'b1, 9'h1FF, 64'd50);
        run_op("R7 imm zext", 1'b0, 3'b000, 32'd10, 32'd77, 1'b1, 9'h1FF, 64'd50);
        run_op("R7 imm s64", 1'b1, 3'b111, 32'd3, 32'd0, 1'b1, 9'h100, 64'd0);
        run_op("R7 imm ignored", 1'b0, 3'b001, 32'd4, 32'd5, 1'b0, 9'h155, 64'd1);
    endtask

    task automatic t_hold();
        logic [63:0] r0;
        logic [3:0] f0;
        r0 = res_out;
        f0 = {ovf, adv_ovf, sticky_ovf, sticky_adv};
        @(negedge clk);
        src_a = 32'hFFFFFFFF; src_b = 32'hFFFFFFFF; acc_in = '1; op_mode = 3'b111;
        repeat (3) @(negedge clk);
        chk("R10 hold res", res_out, r0);
        chk("R10 hold flags", {60'b0, ovf, adv_ovf, sticky_ovf, sticky_adv}, {60'b0, f0});
        chk("R10 idle valid", {63'b0, res_valid}, 64'd0);
    endtask

    task automatic t_sticky_reset();
        run_op("R9 set", 1'b0, 3'b001, 32'd1, 32'd1, 1'b0, 9'd0, 64'h7FFFFFFF);
        do_reset();
        @(negedge clk);
        chk("R9 reset clears", {62'b0, sticky_ovf, sticky_adv}, 64'd0);
        run_op("R9 after reset", 1'b0, 3'b001, 32'd2, 32'd2, 1'b0, 9'd0, 64'd1);
    endtask

    task automatic t_sweep();
        logic [31:0] pool [4];
        pool[0] = 32'h80000000; pool[1] = 32'h7FFFFFFF; pool[2] = 32'hFFFFFFFF; pool[3] = 32'd1;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [63:0] acc;
            a = ($urandom % 3 == 0) ? pool[$urandom % 4] : $urandom;
            b = ($urandom % 3 == 0) ? pool[$urandom % 4] : $urandom;
            acc = {$urandom, $urandom};
            if ($urandom % 4 == 0) acc = {pool[$urandom % 4], pool[$urandom % 4]};
            run_op("R1 sweep", 1'($urandom), 3'($urandom), a, b, 1'($urandom % 4 == 0),
                   9'($urandom), acc);
        end
    endtask

    initial begin
        t_reset();
        t_wrap_narrow();
        t_sat_narrow();
        t_wide_signed();
        t_wide_unsigned();
        t_imm();
        t_hold();
        t_sticky_reset();
        t_sweep();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule